// File: doc/BRIEF.md
# Character Display Bring-Up Sequencer

This block is a host-side controller that takes a character display module from power-on to a configured, blank state through the software reset procedure. It is used where the display's own power-on reset cannot be trusted, for example when the supply rises too slowly. After reset it waits for the supply to settle. It then sends the 8-bit-width function-set code three times, each followed by a fixed wait. In 4-bit bus mode it then sends the one-nibble width switch. It finishes with the configuration instructions: function set, display off, clear and entry mode. When the last of these has completed, it raises `done`.

All waits and enable timings come from the `CLK_HZ` parameter, rounded up to whole clock cycles. Once the three fixed-wait commands are done, the block can do one of two things between instructions. It can read the display's busy flag on DB7 until the flag clears. Or, when `USE_BUSY` is 0, it can use fixed execution waits instead. Display lines, font height, address direction and display shift are fixed at build time by parameters. Text writes after bring-up are not part of this block.

Top module: `lcdinit_seq`

## Requirements
- R1: While reset is asserted and directly after it, `lcd_e`, `lcd_rw`, `lcd_rs` and `done` are all 0.
- R2: The first enable rise comes no earlier than ceil(15 ms × CLK_HZ) cycles after reset is released. With `LOW_VOLT` = 1 the limit is ceil(40 ms × CLK_HZ) cycles.
- R3: The first three transfers each carry 0x30 with `lcd_rs` = 0, and each uses one enable pulse in both bus modes. From the fall of the first to the rise of the second is at least ceil(4.1 ms) of cycles. From the fall of the second to the rise of the third is at least ceil(100 µs) of cycles.
- R4: No busy-flag read (`lcd_rw` = 1 during an enable pulse) starts before the third transfer has completed.
- R5: With `BUS4` = 1, the fourth transfer is the single nibble 0x2 on DB7..DB4. Every later instruction is sent as its upper nibble and then its lower nibble, each on DB7..DB4. DB3..DB0 are driven 0 on every transfer.
- R6: The configuration instructions follow in this order. Function set is 0x20 | (8-bit ? 0x10 : 0) | TWO_LINE<<3 | FONT_TALL<<2. Then display off 0x08, then clear 0x01, then entry mode 0x04 | AUTO_INC<<1 | DISP_SHIFT.
- R7: With `USE_BUSY` = 1, every instruction from the third function set on is followed by status reads (`lcd_rs` = 0, `lcd_rw` = 1). The reads repeat until DB7 is read as 0. In 4-bit mode each read takes two enable pulses, and the flag is taken from the first. No write starts while the display is busy.
- R8: With `USE_BUSY` = 0, no read ever occurs. The wait after clear is at least ceil(2 ms) of cycles, and the wait after each other configuration instruction is at least ceil(50 µs) of cycles.
- R9: Each enable pulse is high for at least ceil(450 ns) of cycles, and enable rises are at least ceil(1000 ns) of cycles apart. `lcd_rs`, `lcd_rw` and the data lines are stable for at least ceil(195 ns) of cycles before each rise, and they do not change while enable is high.
- R10: `done` rises only after the last entry-mode transfer and its wait or poll. It then stays high, and no further enable pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset; the sequence starts when it is released |
| lcd_rs | output | 1 | Register select to the display (0 = instruction or status) |
| lcd_rw | output | 1 | 1 = read status, 0 = write |
| lcd_e | output | 1 | Enable strobe |
| lcd_db_o | output | 8 | Data lines driven to the display; in 4-bit mode the nibble is on bits 7..4 |
| lcd_db_oe | output | 1 | Output enable for the data lines, high on writes |
| lcd_db7_i | input | 1 | DB7 as read back from the display (busy flag) |
| done | output | 1 | Bring-up complete |

## Verification
Two instances are run side by side. One uses the 8-bit bus with fixed waits and the long low-voltage power-on wait. The other uses the 4-bit bus with busy polling, the short power-on wait and the opposite setting of each configuration bit. Between them they show that the instruction codes follow the parameters, that the nibble split and the width switch appear only in 4-bit mode, and that reads appear only when polling is on. A display model holds the busy flag high for a while after each complete instruction. This forces repeated polls, and it shows that a write is never issued into a busy display. Every gap between enable edges is measured against the minimum derived from the clock frequency.

// File: rtl/lcdinit_pkg.sv
package lcdinit_pkg;

  // What follows a transfer: fixed long / short wait, or execution wait (busy poll or fixed)
  typedef enum logic [1:0] {W_LONG, W_SHORT, W_EXEC, W_CLR} post_e;

  typedef struct packed {
    logic [7:0] code;
    logic       single;   // one pulse even on the 4-bit bus
    post_e      post;
  } step_t;

  // Round a duration in ns up to whole clock cycles, at least one.
  function automatic longint ns_to_cyc(longint hz, longint ns);
    longint c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/lcdinit_timer.sv
module lcdinit_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          zero
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == 0);

  // R2 R3 R8: once loaded, a wait never ends early
  a_r3_wait_counts_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != 0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/lcdinit_bus.sv
module lcdinit_bus #(
  parameter int T_SU = 1,
  parameter int T_EH = 1,
  parameter int T_EL = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       go_rd,
  input  logic [7:0] go_data,
  output logic       xfer_done,
  output logic       bf_rd,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [7:0] lcd_db_o,
  input  logic       lcd_db7_i
);
  localparam int TMAX = (T_SU > T_EH) ? ((T_SU > T_EL) ? T_SU : T_EL)
                                      : ((T_EH > T_EL) ? T_EH : T_EL);
  localparam int CW = $clog2(TMAX + 1);

  typedef enum logic [1:0] {B_IDLE, B_SU, B_HI, B_LO} bst_e;
  bst_e          st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= B_IDLE; cnt_q <= '0; xfer_done <= 1'b0; bf_rd <= 1'b0;
      lcd_rs <= 1'b0; lcd_rw <= 1'b0; lcd_e <= 1'b0; lcd_db_o <= '0;
    end else begin
      xfer_done <= 1'b0;
      case (st_q)
        B_IDLE: if (go) begin
          lcd_rs   <= 1'b0;
          lcd_rw   <= go_rd;
          lcd_db_o <= go_rd ? 8'h00 : go_data;
          cnt_q    <= CW'(T_SU - 1);
          st_q     <= B_SU;
        end
        B_SU: if (cnt_q == 0) begin
          lcd_e <= 1'b1; cnt_q <= CW'(T_EH - 1); st_q <= B_HI;
        end else cnt_q <= cnt_q - 1'b1;
        B_HI: if (cnt_q == 0) begin
          lcd_e <= 1'b0; bf_rd <= lcd_db7_i; cnt_q <= CW'(T_EL - 1); st_q <= B_LO;
        end else cnt_q <= cnt_q - 1'b1;
        default: if (cnt_q == 0) begin
          xfer_done <= 1'b1; st_q <= B_IDLE;
        end else cnt_q <= cnt_q - 1'b1;
      endcase
    end
  end

  // checker state: length of the current high phase
  logic [15:0] hi_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     hi_run_q <= '0;
    else if (!lcd_e)                hi_run_q <= '0;
    else if (hi_run_q != 16'hFFFF)  hi_run_q <= hi_run_q + 1'b1;
  end

  a_r9_stable_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_e && $past(lcd_e)) |-> ($stable(lcd_rw) && $stable(lcd_rs) && $stable(lcd_db_o)));
  a_r9_min_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_e) |-> (hi_run_q >= 16'(T_EH)));
endmodule

// File: rtl/lcdinit_seq.sv
module lcdinit_seq
  import lcdinit_pkg::*;
#(
  parameter longint CLK_HZ     = 50_000_000,
  parameter bit     LOW_VOLT   = 1'b0,
  parameter bit     BUS4       = 1'b0,
  parameter bit     USE_BUSY   = 1'b1,
  parameter bit     TWO_LINE   = 1'b1,
  parameter bit     FONT_TALL  = 1'b0,
  parameter bit     AUTO_INC   = 1'b1,
  parameter bit     DISP_SHIFT = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [7:0] lcd_db_o,
  output logic       lcd_db_oe,
  input  logic       lcd_db7_i,
  output logic       done
);
  localparam longint T_PWR  = ns_to_cyc(CLK_HZ, LOW_VOLT ? 64'd40_000_000 : 64'd15_000_000);
  localparam longint T_41   = ns_to_cyc(CLK_HZ, 64'd4_100_000);
  localparam longint T_100  = ns_to_cyc(CLK_HZ, 64'd100_000);
  localparam longint T_EXEC = ns_to_cyc(CLK_HZ, 64'd50_000);
  localparam longint T_CLR  = ns_to_cyc(CLK_HZ, 64'd2_000_000);
  localparam int     T_SU   = int'(ns_to_cyc(CLK_HZ, 64'd195));
  localparam int     T_EH   = int'(ns_to_cyc(CLK_HZ, 64'd450));
  localparam int     T_EL   = int'(ns_to_cyc(CLK_HZ, 64'd550));
  localparam longint T_MAX  = (T_PWR > T_41) ? T_PWR : T_41;
  localparam int     TW     = $clog2(T_MAX + 1);
  localparam int     NSTEP  = BUS4 ? 8 : 7;
  localparam int     SW     = $clog2(NSTEP);

  // Instruction list for the chosen bus mode
  function automatic step_t step_at(logic [SW-1:0] idx);
    step_t s;
    int    k;
    s.code = 8'h00; s.single = 1'b0; s.post = W_EXEC;
    if (idx < 3) begin
      s.code   = 8'h30;
      s.single = 1'b1;
      s.post   = (idx == 0) ? W_LONG : (idx == 1) ? W_SHORT : W_EXEC;
    end else if (BUS4 && idx == 3) begin
      s.code = 8'h20; s.single = 1'b1;
    end else begin
      k = int'(idx) - (BUS4 ? 4 : 3);
      case (k)
        0:       s.code = {3'b001, !BUS4, TWO_LINE, FONT_TALL, 2'b00};
        1:       s.code = 8'h08;
        2:       begin s.code = 8'h01; s.post = W_CLR; end
        default: s.code = {5'b00000, 1'b1, AUTO_INC, DISP_SHIFT};
      endcase
    end
    return s;
  endfunction

  typedef enum logic [2:0] {S_BOOT, S_PWR, S_SEND, S_SEND_LO, S_POLL, S_POLL_LO, S_WAIT, S_DONE} st_e;
  st_e           st_q, st_d;
  logic [SW-1:0] step_q, step_d;
  logic          bf_q, bf_d, pend_q;
  logic          go, go_rd, xfer_done, bf_rd, tload, tzero;
  logic [7:0]    go_data;
  logic [TW-1:0] tval;
  step_t         cur;

  assign cur = step_at(step_q);

  always_comb begin
    logic do_post, do_adv, bf_now;
    st_d = st_q; step_d = step_q; bf_d = bf_q;
    tload = 1'b0; tval = '0; go = 1'b0; go_rd = 1'b0; go_data = 8'h00;
    do_post = 1'b0; do_adv = 1'b0; bf_now = 1'b0;
    case (st_q)
      S_BOOT: begin tload = 1'b1; tval = TW'(T_PWR); st_d = S_PWR; end
      S_PWR:  if (tzero) st_d = S_SEND;
      S_SEND, S_SEND_LO: begin
        go = !pend_q;
        if (st_q == S_SEND_LO) go_data = {cur.code[3:0], 4'h0};
        else                   go_data = BUS4 ? {cur.code[7:4], 4'h0} : cur.code;
        if (xfer_done) begin
          if (st_q == S_SEND && BUS4 && !cur.single) st_d = S_SEND_LO;
          else                                       do_post = 1'b1;
        end
      end
      S_POLL, S_POLL_LO: begin
        go = !pend_q; go_rd = 1'b1;
        if (xfer_done) begin
          if (st_q == S_POLL && BUS4) begin
            bf_d = bf_rd; st_d = S_POLL_LO;
          end else begin
            bf_now = (st_q == S_POLL) ? bf_rd : bf_q;
            if (bf_now) st_d = S_POLL;
            else        do_adv = 1'b1;
          end
        end
      end
      S_WAIT: if (tzero) do_adv = 1'b1;
      default: ;
    endcase
    if (do_post) begin
      case (cur.post)
        W_LONG:  tval = TW'(T_41);
        W_SHORT: tval = TW'(T_100);
        W_CLR:   tval = TW'(T_CLR);
        default: tval = TW'(T_EXEC);
      endcase
      if (cur.post == W_LONG || cur.post == W_SHORT || !USE_BUSY) begin
        tload = 1'b1; st_d = S_WAIT;
      end else st_d = S_POLL;
    end
    if (do_adv) begin
      if (step_q == SW'(NSTEP - 1)) st_d = S_DONE;
      else begin step_d = step_q + 1'b1; st_d = S_SEND; end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_BOOT; step_q <= '0; bf_q <= 1'b0; pend_q <= 1'b0;
    end else begin
      st_q <= st_d; step_q <= step_d; bf_q <= bf_d;
      if (go)             pend_q <= 1'b1;
      else if (xfer_done) pend_q <= 1'b0;
    end
  end

  lcdinit_timer #(.TW(TW)) tmr_i (
    .clk(clk), .rst_n(rst_n), .load(tload), .val(tval), .zero(tzero)
  );

  lcdinit_bus #(.T_SU(T_SU), .T_EH(T_EH), .T_EL(T_EL)) bus_i (
    .clk(clk), .rst_n(rst_n), .go(go), .go_rd(go_rd), .go_data(go_data),
    .xfer_done(xfer_done), .bf_rd(bf_rd), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
    .lcd_e(lcd_e), .lcd_db_o(lcd_db_o), .lcd_db7_i(lcd_db7_i)
  );

  assign lcd_db_oe = !lcd_rw;
  assign done      = (st_q == S_DONE);

  // ---- checker state ----
  logic [TW-1:0] up_q;
  logic [1:0]    wr_seen_q;
  logic          e_d_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= '0; wr_seen_q <= '0; e_d_q <= 1'b0;
    end else begin
      e_d_q <= lcd_e;
      if (up_q < TW'(T_PWR)) up_q <= up_q + 1'b1;
      if (e_d_q && !lcd_e && !lcd_rw && wr_seen_q != 2'd3) wr_seen_q <= wr_seen_q + 1'b1;
    end
  end

  a_r2_quiet_after_power: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_e |-> (up_q >= TW'(T_PWR)));
  a_r4_no_early_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_e && lcd_rw) |-> (wr_seen_q == 2'd3));
  a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  a_r10_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !lcd_e);
  generate
    if (!USE_BUSY) begin : g_fixed
      a_r8_never_reads: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_e |-> !lcd_rw);
    end
  endgenerate
endmodule

// File: tb/lcdinit_mon.sv
module lcdinit_mon #(
  parameter longint CLK_HZ     = 1_000_000,
  parameter bit     LOW_VOLT   = 1'b0,
  parameter bit     BUS4       = 1'b0,
  parameter bit     USE_BUSY   = 1'b0,
  parameter bit     TWO_LINE   = 1'b0,
  parameter bit     FONT_TALL  = 1'b0,
  parameter bit     AUTO_INC   = 1'b1,
  parameter bit     DISP_SHIFT = 1'b0,
  parameter int     BUSY_CYC   = 80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       e,
  input  logic       rs,
  input  logic       rw,
  input  logic [7:0] db_o,
  input  logic       db_oe,
  input  logic       done,
  output logic       db7_i,
  output int         errs,
  output int         chks,
  output logic       fin
);
  typedef struct {logic [7:0] d; longint gap; bit cend; string tag;} item_t;
  item_t  q[$];
  item_t  cur;
  longint tpwr, t41, t100, texec, tclr, tsu, teh, tper;
  longint cyc, last_chg, last_rise, rise_c, wfall;
  int     reads, writes, busy, post_cnt;
  logic   prev_e;
  logic [10:0] prev_sig;
  bit     done_seen, rchk;

  function automatic longint cyc_of(longint ns);
    longint c;
    c = (ns * CLK_HZ + 999_999_999) / 1_000_000_000;
    return (c < 1) ? 1 : c;
  endfunction

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // driver: expected transfer list
  task automatic push(logic [7:0] d, longint gap, bit cend, string tag);
    item_t it;
    it.d = d; it.gap = gap; it.cend = cend; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic push_cmd(logic [7:0] c, longint gap, string tag);
    if (BUS4) begin
      push({c[7:4], 4'h0}, gap, 1'b0, "R5");
      push({c[3:0], 4'h0}, 0, 1'b1, "R5");
    end else push(c, gap, 1'b1, tag);
  endtask

  initial begin
    longint g;
    errs = 0; chks = 0; fin = 1'b0; db7_i = 1'b0;
    cyc = 0; last_chg = 0; last_rise = -1; rise_c = 0; wfall = 0;
    reads = 0; writes = 0; busy = 0; post_cnt = 0;
    prev_e = 1'b0; prev_sig = '0; done_seen = 1'b0; rchk = 1'b0;
    tpwr  = cyc_of(LOW_VOLT ? 40_000_000 : 15_000_000);
    t41   = cyc_of(4_100_000);
    t100  = cyc_of(100_000);
    texec = cyc_of(50_000);
    tclr  = cyc_of(2_000_000);
    tsu   = cyc_of(195);
    teh   = cyc_of(450);
    tper  = cyc_of(1000);
    g = USE_BUSY ? 0 : texec;
    // R3: three width commands; R2 gap before the first
    push(8'h30, tpwr, 1'b1, "R2");
    push(8'h30, t41, 1'b1, "R3");
    push(8'h30, t100, 1'b1, "R3");
    if (BUS4) push(8'h20, g, 1'b1, "R5");
    // R6 configuration sequence
    push_cmd({3'b001, !BUS4, TWO_LINE, FONT_TALL, 2'b00}, g, "R6");
    push_cmd(8'h08, g, "R6");
    push_cmd(8'h01, g, "R6");
    push_cmd({5'b00000, 1'b1, AUTO_INC, DISP_SHIFT}, USE_BUSY ? 0 : tclr, "R8");
  end

  always @(negedge clk) begin
    logic [10:0] sig;
    sig = {rs, rw, db_o, db_oe};
    if (!rst_n) begin
      if (!rchk) begin
        rchk = 1'b1;
        chk(e == 1'b0, "R1", "enable in reset", longint'(e), 0);
        chk(done == 1'b0, "R1", "done in reset", longint'(done), 0);
        chk(rw == 1'b0 && rs == 1'b0, "R1", "rs/rw in reset", longint'({rs, rw}), 0);
      end
    end else begin
      cyc++;
      if (sig != prev_sig) begin
        if (e && prev_e) chk(1'b0, "R9", "bus changed while enable high", longint'(sig), longint'(prev_sig));
        last_chg = cyc;
      end
      if (e && !prev_e) begin
        chk(cyc - last_chg >= tsu, "R9", "setup before rise", cyc - last_chg, tsu);
        if (last_rise >= 0) chk(cyc - last_rise >= tper, "R9", "rise-to-rise", cyc - last_rise, tper);
        last_rise = cyc; rise_c = cyc;
        chk(!done_seen, "R10", "pulse after done", 1, 0);
        if (rw) begin
          reads++;
          chk(USE_BUSY, "R8", "read with fixed waits", 1, 0);
          chk(writes >= 3, "R4", "read before third command", writes, 3);
          chk(rs == 1'b0, "R7", "status read rs", longint'(rs), 0);
        end else begin
          if (USE_BUSY) chk(busy == 0, "R7", "write while busy", busy, 0);
          if (q.size() == 0) chk(1'b0, "R10", "unexpected extra write", writes, writes);
          else begin
            cur = q[0];
            chk(cyc - wfall >= cur.gap, cur.tag, "gap before write", cyc - wfall, cur.gap);
          end
        end
      end
      if (!e && prev_e) begin
        chk(cyc - rise_c >= teh, "R9", "enable high width", cyc - rise_c, teh);
        if (!rw && q.size() != 0) begin
          cur = q.pop_front();
          chk(db_o == cur.d, cur.tag, "write data", longint'(db_o), longint'(cur.d));
          chk(rs == 1'b0 && db_oe == 1'b1, "R6", "write rs/oe", longint'({rs, db_oe}), 1);
          wfall = cyc; writes++;
          if (cur.cend) busy = BUSY_CYC;
        end
      end
      if (done && !done_seen) begin
        done_seen = 1'b1;
        chk(q.size() == 0, "R10", "transfers left at done", q.size(), 0);
      end
      if (done_seen) begin
        if (!done) chk(1'b0, "R10", "done dropped", 0, 1);
        post_cnt++;
        if (post_cnt == 300 && !fin) begin
          chk(e == 1'b0 && done == 1'b1, "R10", "idle after done", longint'({done, e}), 2);
          if (USE_BUSY) chk(reads > 6, "R7", "status reads seen", reads, 7);
          else          chk(reads == 0, "R8", "status reads seen", reads, 0);
          fin = 1'b1;
        end
      end
      if (busy > 0) busy--;
      db7_i = (busy != 0);
    end
    prev_e = e; prev_sig = sig;
  end
endmodule

// File: tb/lcdinit_seq_tb_top.sv
module lcdinit_seq_tb_top;
  localparam longint BHZ = 1_000_000;  // scaled frequency so the waits fit the run

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic       rs8, rw8, e8, oe8, b8, done8, fin8;
  logic [7:0] db8;
  logic       rs4, rw4, e4, oe4, b4, done4, fin4;
  logic [7:0] db4;
  int         err8, chk8, err4, chk4;
  int         wd_err = 0;

  // 8-bit bus, fixed waits, low-voltage power-on wait
  lcdinit_seq #(.CLK_HZ(BHZ), .LOW_VOLT(1'b1), .BUS4(1'b0), .USE_BUSY(1'b0),
    .TWO_LINE(1'b1), .FONT_TALL(1'b0), .AUTO_INC(1'b1), .DISP_SHIFT(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .lcd_rs(rs8), .lcd_rw(rw8), .lcd_e(e8),
    .lcd_db_o(db8), .lcd_db_oe(oe8), .lcd_db7_i(b8), .done(done8));

  lcdinit_mon #(.CLK_HZ(BHZ), .LOW_VOLT(1'b1), .BUS4(1'b0), .USE_BUSY(1'b0),
    .TWO_LINE(1'b1), .FONT_TALL(1'b0), .AUTO_INC(1'b1), .DISP_SHIFT(1'b0)) mon8_i (
    .clk(clk), .rst_n(rst_n), .e(e8), .rs(rs8), .rw(rw8), .db_o(db8), .db_oe(oe8),
    .done(done8), .db7_i(b8), .errs(err8), .chks(chk8), .fin(fin8));

  // 4-bit bus, busy polling, opposite configuration bits
  lcdinit_seq #(.CLK_HZ(BHZ), .LOW_VOLT(1'b0), .BUS4(1'b1), .USE_BUSY(1'b1),
    .TWO_LINE(1'b0), .FONT_TALL(1'b1), .AUTO_INC(1'b0), .DISP_SHIFT(1'b1)) dut4_i (
    .clk(clk), .rst_n(rst_n), .lcd_rs(rs4), .lcd_rw(rw4), .lcd_e(e4),
    .lcd_db_o(db4), .lcd_db_oe(oe4), .lcd_db7_i(b4), .done(done4));

  lcdinit_mon #(.CLK_HZ(BHZ), .LOW_VOLT(1'b0), .BUS4(1'b1), .USE_BUSY(1'b1),
    .TWO_LINE(1'b0), .FONT_TALL(1'b1), .AUTO_INC(1'b0), .DISP_SHIFT(1'b1)) mon4_i (
    .clk(clk), .rst_n(rst_n), .e(e4), .rs(rs4), .rw(rw4), .db_o(db4), .db_oe(oe4),
    .done(done4), .db7_i(b4), .errs(err4), .chks(chk4), .fin(fin4));

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 150_000 && !(fin8 && fin4); i++) @(negedge clk);
    if (!(fin8 && fin4)) begin
      wd_err = 1;
      $display("FAIL R10 watchdog: actual=%0d expected=%0d", {fin8, fin4}, 3);
    end
    $display("Result: errors=%0d of %0d checks", err8 + err4 + wd_err, chk8 + chk4 + wd_err);
    $finish;
  end
endmodule